// File: doc/BRIEF.md
# Banked System Address Decoder

This block sits between a 16-bit processor's bus interface and the memories and peripherals of the system. Each access request carries a 24-bit byte address, a size code and a direction. The block turns the request into decoded beats. Each beat carries a one-hot target select, the offset local to that target, the write data for that beat and, for reads that hit nothing, a fixed open-bus value. Coarse decoding uses address bits 23:20. Some regions are narrowed further by bits 19:16. The second program-ROM window is moved by a bank-base register, and a dedicated strobe loads that register.

Requests enter on a valid/ready stream and beats leave on a valid/ready stream. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high, and its first beat appears on the output one cycle later. An output beat stays on the port until `out_ready` is high. While a beat is stalled, or while the second half of a long access is still to be sent, `in_ready` is low. A long access leaves as two word beats: the high half first, at the request address, then the low half at address + 2. The bank-base load strobe is a plain control pin with no handshake.

Top module: `sysbus_addr_decoder`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high. The bank base resets to 0x100000 when the parameter `ROM_BYTES` exceeds 1 MiB, and to 0 otherwise.
- R2: A read with address bits 23:20 equal to 0x0 selects program ROM, with offset equal to address bits 19:0.
- R3: A read with bits 23:20 equal to 0x2 selects program ROM at offset (bank base + bits 19:0) modulo 2^24. A pulse on `bank_load` copies `bank_value` into the bank base, and later accesses use the new value.
- R4: Any access with bits 23:20 equal to 0x1 selects work RAM with offset bits 15:0, so the 64 KiB RAM repeats across the whole region.
- R5: Reads with bits 23:20 = 0xC and bits 19:16 equal to 0 or 1 select the BIOS ROM, with offset bits 19:0. Reads or writes whose top byte is 0xD0, 0x40 or 0x80 select backup SRAM, palette and memory card respectively, with offset bits 15:0.
- R6: Reads in region 0x3 decode bits 19:16 as follows: 0xC video, 0x0 control port 1, 0x4 control port 2, 0x8 control port 3, 0x2 coin port. Each uses offset bits 15:0.
- R7: Writes in region 0x3 decode bits 19:16 as follows: 0xC video, 0x8 clock-chip port, 0x2 sound-command port, 0xA settings port. A write with top byte 0x2F selects the bank-switch port. Each uses offset bits 15:0.
- R8: A byte write to exactly 0x300001 selects only the watchdog target, with offset 0x0001. Any other write that matches no rule selects nothing. This covers writes to the ROM regions 0x0, 0x2 (sub-field other than 0xF) and 0xC.
- R9: A read that matches no rule selects nothing and has offset 0. Its `out_obus` is 0x00FF for a byte read, 0xF0F0 for a word read, and 0xFF00 on each beat of a long read, so the pair forms 0xFF00FF00. `out_obus` is 0 on every mapped beat and on every write.
- R10: Size codes are 0 byte, 1 word and 2 long. Byte and word requests give one beat with `out_last` high and `out_wdata` = `in_wdata[15:0]`. A long request gives a beat at the address carrying `in_wdata[31:16]`, then a beat at (address + 2) mod 2^24 carrying `in_wdata[15:0]`, with `out_last` high only on the second. Each beat is decoded on its own address. Reads carry `out_wdata` = 0, and `out_size` repeats the request size on every beat.
- R11: An accepted request's first beat is valid on the next cycle. A beat held while `out_ready` is low keeps all its fields. `in_ready` is high exactly when no second long beat is pending and the output stage is empty or being drained.
- R12: `out_sel` has at most one bit set. Bit positions: 0 program ROM, 1 work RAM, 2 BIOS, 3 SRAM, 4 palette, 5 video, 6 control 1, 7 control 2, 8 control 3, 9 coin, 10 memory card, 11 clock chip, 12 sound command, 13 settings, 14 bank switch, 15 watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_addr | input | 24 | Byte address |
| in_size | input | 2 | 0 byte, 1 word, 2 long |
| in_wr | input | 1 | 1 write, 0 read |
| in_wdata | input | 32 | Write data; long uses all 32 bits, others bits 15:0 |
| bank_load | input | 1 | Load strobe for the bank base |
| bank_value | input | 24 | New bank base |
| out_valid | output | 1 | Beat valid |
| out_ready | input | 1 | Beat consumed when high together with out_valid |
| out_sel | output | 16 | One-hot target select |
| out_offset | output | 24 | Offset inside the selected target |
| out_wr | output | 1 | Beat direction |
| out_size | output | 2 | Size of the originating request |
| out_wdata | output | 16 | Write data for this beat |
| out_obus | output | 16 | Open-bus value for an unmapped read |
| out_last | output | 1 | Final beat of the request |

## Verification
The bench aims at the edges between decode windows. It reads the last byte of the direct ROM window, the last word of the BIOS window and the first word past it, and a long read that starts in ROM and ends in RAM. A design that decodes only the first address of a long access would send the RAM half to ROM. Writes go to ROM regions, to region 0x3 sub-field 0 and to the watchdog address with both byte and word size. A design that takes direction or size from the wrong signal would select a target on a write, or fire the watchdog on a word access. The bank base is checked at its reset value and after reloads, including a sum that wraps past 2^24. The open-bus patterns are checked for every size. Random traffic under random back-pressure checks that stalled beats hold still and that no request slips in between the two halves of a long access.

// File: rtl/sysbus_dec_pkg.sv
package sysbus_dec_pkg;
  localparam int AW       = 24;   // byte address width
  localparam int WIN_W    = 20;   // bits inside one coarse region
  localparam int LOCAL_W  = 16;   // bits kept for RAM and port targets
  localparam int BEAT_W   = 16;   // data width of one beat
  localparam int NTGT     = 16;   // number of decoded targets

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  localparam int T_PROM  = 0;
  localparam int T_RAM   = 1;
  localparam int T_BIOS  = 2;
  localparam int T_SRAM  = 3;
  localparam int T_PAL   = 4;
  localparam int T_VIDEO = 5;
  localparam int T_CTL1  = 6;
  localparam int T_CTL2  = 7;
  localparam int T_CTL3  = 8;
  localparam int T_COIN  = 9;
  localparam int T_CARD  = 10;
  localparam int T_CLOCK = 11;
  localparam int T_SOUND = 12;
  localparam int T_SETUP = 13;
  localparam int T_BANKW = 14;
  localparam int T_WDOG  = 15;

  localparam logic [BEAT_W-1:0] OB_BYTE = 16'h00FF;
  localparam logic [BEAT_W-1:0] OB_WORD = 16'hF0F0;
  localparam logic [BEAT_W-1:0] OB_LONG = 16'hFF00;

  localparam logic [LOCAL_W-1:0] KICK_LOW  = 16'h0001;
  localparam logic [AW-1:0]      BANK_HIGH = 24'h100000;
  localparam longint             WIN_BYTES = longint'(1) << WIN_W;
endpackage

// File: rtl/sysbus_bank_base.sv
module sysbus_bank_base
  import sysbus_dec_pkg::*;
#(
  parameter int ROM_BYTES = 2 * 1024 * 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] value,
  output logic [AW-1:0] base
);
  localparam logic [AW-1:0] BASE_RST = (longint'(ROM_BYTES) > WIN_BYTES) ? BANK_HIGH : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)    base <= BASE_RST;
    else if (load) base <= value;
  end
endmodule

// File: rtl/sysbus_region_decode.sv
module sysbus_region_decode
  import sysbus_dec_pkg::*;
(
  input  logic [AW-1:0]     addr,
  input  logic [1:0]        size,
  input  logic              wr,
  input  logic [AW-1:0]     bank,
  output logic [NTGT-1:0]   sel,
  output logic [AW-1:0]     offset,
  output logic [BEAT_W-1:0] obus
);
  logic [3:0]    region, sub;
  logic [AW-1:0] win_off, loc_off;

  assign region  = addr[AW-1 -: 4];
  assign sub     = addr[AW-5 -: 4];
  assign win_off = {{(AW-WIN_W){1'b0}}, addr[WIN_W-1:0]};
  assign loc_off = {{(AW-LOCAL_W){1'b0}}, addr[LOCAL_W-1:0]};

  always_comb begin
    sel = '0;
    case (region)
      4'h0: if (!wr) sel[T_PROM] = 1'b1;
      4'h1: sel[T_RAM] = 1'b1;
      4'h2: begin
        if (!wr)              sel[T_PROM]  = 1'b1;
        else if (sub == 4'hF) sel[T_BANKW] = 1'b1;
      end
      4'h3: begin
        if (wr) begin
          case (sub)
            4'hC: sel[T_VIDEO] = 1'b1;
            4'h8: sel[T_CLOCK] = 1'b1;
            4'h2: sel[T_SOUND] = 1'b1;
            4'hA: sel[T_SETUP] = 1'b1;
            4'h0: if (size == SZ_BYTE && addr[LOCAL_W-1:0] == KICK_LOW) sel[T_WDOG] = 1'b1;
            default: ;
          endcase
        end else begin
          case (sub)
            4'hC: sel[T_VIDEO] = 1'b1;
            4'h0: sel[T_CTL1]  = 1'b1;
            4'h4: sel[T_CTL2]  = 1'b1;
            4'h8: sel[T_CTL3]  = 1'b1;
            4'h2: sel[T_COIN]  = 1'b1;
            default: ;
          endcase
        end
      end
      4'h4: if (sub == 4'h0) sel[T_PAL]  = 1'b1;
      4'h8: if (sub == 4'h0) sel[T_CARD] = 1'b1;
      4'hC: if (!wr && sub <= 4'h1) sel[T_BIOS] = 1'b1;
      4'hD: if (sub == 4'h0) sel[T_SRAM] = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    if (sel[T_PROM])      offset = (region == 4'h2) ? bank + win_off : win_off;
    else if (sel[T_BIOS]) offset = win_off;
    else if (|sel)        offset = loc_off;
    else                  offset = '0;
  end

  always_comb begin
    obus = '0;
    if (!wr && sel == '0) begin
      case (size)
        SZ_BYTE: obus = OB_BYTE;
        SZ_LONG: obus = OB_LONG;
        default: obus = OB_WORD;
      endcase
    end
  end
endmodule

// File: rtl/sysbus_beat_stage.sv
module sysbus_beat_stage
  import sysbus_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     in_addr,
  input  logic [1:0]        in_size,
  input  logic              in_wr,
  input  logic [2*BEAT_W-1:0] in_wdata,
  output logic [AW-1:0]     dec_addr,
  output logic [1:0]        dec_size,
  output logic              dec_wr,
  input  logic [NTGT-1:0]   dec_sel,
  input  logic [AW-1:0]     dec_offset,
  input  logic [BEAT_W-1:0] dec_obus,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NTGT-1:0]   out_sel,
  output logic [AW-1:0]     out_offset,
  output logic              out_wr,
  output logic [1:0]        out_size,
  output logic [BEAT_W-1:0] out_wdata,
  output logic [BEAT_W-1:0] out_obus,
  output logic              out_last
);
  localparam logic [AW-1:0] HALF_STEP = AW'(BEAT_W / 8);

  logic              pend_q, pend_wr_q;
  logic [AW-1:0]     pend_addr_q;
  logic [1:0]        pend_size_q;
  logic [BEAT_W-1:0] pend_wdata_q, beat_wdata;
  logic              advance, is_long;

  assign advance  = !out_valid || out_ready;
  assign in_ready = !pend_q && advance;
  assign is_long  = (in_size == SZ_LONG);

  assign dec_addr = pend_q ? pend_addr_q : in_addr;
  assign dec_size = pend_q ? pend_size_q : in_size;
  assign dec_wr   = pend_q ? pend_wr_q   : in_wr;

  always_comb begin
    if (pend_q)      beat_wdata = pend_wdata_q;
    else if (!in_wr) beat_wdata = '0;
    else if (is_long) beat_wdata = in_wdata[2*BEAT_W-1:BEAT_W];
    else             beat_wdata = in_wdata[BEAT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_sel      <= '0;
      out_offset   <= '0;
      out_wr       <= 1'b0;
      out_size     <= SZ_BYTE;
      out_wdata    <= '0;
      out_obus     <= '0;
      out_last     <= 1'b0;
      pend_q       <= 1'b0;
      pend_wr_q    <= 1'b0;
      pend_addr_q  <= '0;
      pend_size_q  <= SZ_BYTE;
      pend_wdata_q <= '0;
    end else if (advance) begin
      if (pend_q || in_valid) begin
        out_valid  <= 1'b1;
        out_sel    <= dec_sel;
        out_offset <= dec_offset;
        out_wr     <= dec_wr;
        out_size   <= dec_size;
        out_wdata  <= beat_wdata;
        out_obus   <= dec_obus;
      end else begin
        out_valid  <= 1'b0;
      end
      if (pend_q) begin
        out_last <= 1'b1;
        pend_q   <= 1'b0;
      end else if (in_valid) begin
        out_last <= !is_long;
        if (is_long) begin
          pend_q       <= 1'b1;
          pend_addr_q  <= in_addr + HALF_STEP;
          pend_size_q  <= in_size;
          pend_wr_q    <= in_wr;
          pend_wdata_q <= in_wr ? in_wdata[BEAT_W-1:0] : '0;
        end
      end
    end
  end
endmodule

// File: rtl/sysbus_addr_decoder.sv
module sysbus_addr_decoder
  import sysbus_dec_pkg::*;
#(
  parameter int ROM_BYTES = 2 * 1024 * 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     in_addr,
  input  logic [1:0]        in_size,
  input  logic              in_wr,
  input  logic [2*BEAT_W-1:0] in_wdata,
  input  logic              bank_load,
  input  logic [AW-1:0]     bank_value,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NTGT-1:0]   out_sel,
  output logic [AW-1:0]     out_offset,
  output logic              out_wr,
  output logic [1:0]        out_size,
  output logic [BEAT_W-1:0] out_wdata,
  output logic [BEAT_W-1:0] out_obus,
  output logic              out_last
);
  logic [AW-1:0]     bank_base, dec_addr, dec_offset;
  logic [1:0]        dec_size;
  logic              dec_wr;
  logic [NTGT-1:0]   dec_sel;
  logic [BEAT_W-1:0] dec_obus;

  sysbus_bank_base #(.ROM_BYTES(ROM_BYTES)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(bank_load), .value(bank_value), .base(bank_base)
  );

  sysbus_region_decode u_dec (
    .addr(dec_addr), .size(dec_size), .wr(dec_wr), .bank(bank_base),
    .sel(dec_sel), .offset(dec_offset), .obus(dec_obus)
  );

  sysbus_beat_stage u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_size(in_size), .in_wr(in_wr), .in_wdata(in_wdata),
    .dec_addr(dec_addr), .dec_size(dec_size), .dec_wr(dec_wr),
    .dec_sel(dec_sel), .dec_offset(dec_offset), .dec_obus(dec_obus),
    .out_valid(out_valid), .out_ready(out_ready), .out_sel(out_sel),
    .out_offset(out_offset), .out_wr(out_wr), .out_size(out_size),
    .out_wdata(out_wdata), .out_obus(out_obus), .out_last(out_last)
  );
endmodule

// File: rtl/sysbus_addr_decoder_chk.sv
module sysbus_addr_decoder_chk
  import sysbus_dec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [NTGT-1:0]   out_sel,
  input logic [AW-1:0]     out_offset,
  input logic              out_wr,
  input logic [1:0]        out_size,
  input logic [BEAT_W-1:0] out_wdata,
  input logic [BEAT_W-1:0] out_obus,
  input logic              out_last
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_sel)); // R12

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sel) && $stable(out_offset)
      && $stable(out_wdata) && $stable(out_obus) && $stable(out_last)); // R11

  AST_NO_ACCEPT_MID_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> !in_ready); // R11

  AST_LONG_TAIL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && out_last); // R10

  AST_OBUS_ONLY_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_obus != '0) |-> (out_sel == '0) && !out_wr); // R9

  AST_KICK_IS_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sel[T_WDOG] |-> out_wr && (out_size == SZ_BYTE)
      && (out_offset == AW'(KICK_LOW))); // R8

  AST_ROM_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wr |-> !out_sel[T_PROM] && !out_sel[T_BIOS]); // R8

  AST_RAM_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sel[T_RAM] |-> (out_offset[AW-1:LOCAL_W] == '0)); // R4
endmodule

bind sysbus_addr_decoder sysbus_addr_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_sel(out_sel), .out_offset(out_offset),
  .out_wr(out_wr), .out_size(out_size), .out_wdata(out_wdata),
  .out_obus(out_obus), .out_last(out_last)
);

// File: tb/tb_sysbus_addr_decoder.sv
module tb_sysbus_addr_decoder;
  localparam int ROM_BYTES = 2 * 1024 * 1024;
  localparam int S_PROM = 0, S_RAM = 1, S_BIOS = 2, S_SRAM = 3, S_PAL = 4, S_VID = 5,
                 S_C1 = 6, S_C2 = 7, S_C3 = 8, S_COIN = 9, S_CARD = 10, S_CLK = 11,
                 S_SND = 12, S_SET = 13, S_BSW = 14, S_KICK = 15;

  typedef struct packed {
    logic [15:0] sel;
    logic [23:0] off;
    logic        wr;
    logic [1:0]  sz;
    logic [15:0] wd;
    logic [15:0] ob;
    logic        last;
  } beat_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_wr = 1'b0, bank_load = 1'b0, out_ready = 1'b0;
  logic [23:0] in_addr = '0, bank_value = '0;
  logic [1:0]  in_size = '0;
  logic [31:0] in_wdata = '0;
  logic in_ready, out_valid, out_wr, out_last;
  logic [15:0] out_sel, out_wdata, out_obus;
  logic [23:0] out_offset;
  logic [1:0]  out_size;

  beat_t expq[$];
  string tagq[$];
  int n_cmp = 0, n_bad = 0;
  logic [23:0] mbank;
  bit rand_ready = 0, done = 0;

  always #5 clk = ~clk;

  sysbus_addr_decoder #(.ROM_BYTES(ROM_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_size(in_size), .in_wr(in_wr), .in_wdata(in_wdata),
    .bank_load(bank_load), .bank_value(bank_value), .out_valid(out_valid),
    .out_ready(out_ready), .out_sel(out_sel), .out_offset(out_offset),
    .out_wr(out_wr), .out_size(out_size), .out_wdata(out_wdata),
    .out_obus(out_obus), .out_last(out_last)
  );

  function automatic bit blk(input logic [23:0] a, input logic [23:0] lo);
    return (a >= lo) && (a <= lo + 24'h00FFFF);
  endfunction

  function automatic beat_t model(input logic [23:0] a, input logic [1:0] sz, input logic wr,
                                  input logic [15:0] wd, input logic last);
    beat_t b;
    int s;
    logic [23:0] off;
    logic [23:0] lo16, lo20;
    lo16 = {8'h00, a[15:0]};
    lo20 = a & 24'h0FFFFF;
    s = -1;
    off = lo16;
    if (!wr) begin
      if (a <= 24'h0FFFFF) begin s = S_PROM; off = lo20; end
      else if (a <= 24'h1FFFFF) s = S_RAM;
      else if (a <= 24'h2FFFFF) begin s = S_PROM; off = mbank + lo20; end
      else if (blk(a, 24'h300000)) s = S_C1;
      else if (blk(a, 24'h320000)) s = S_COIN;
      else if (blk(a, 24'h340000)) s = S_C2;
      else if (blk(a, 24'h380000)) s = S_C3;
      else if (blk(a, 24'h3C0000)) s = S_VID;
      else if (blk(a, 24'h400000)) s = S_PAL;
      else if (blk(a, 24'h800000)) s = S_CARD;
      else if (a >= 24'hC00000 && a <= 24'hC1FFFF) begin s = S_BIOS; off = lo20; end
      else if (blk(a, 24'hD00000)) s = S_SRAM;
    end else begin
      if (a >= 24'h100000 && a <= 24'h1FFFFF) s = S_RAM;
      else if (blk(a, 24'h2F0000)) s = S_BSW;
      else if (blk(a, 24'h320000)) s = S_SND;
      else if (blk(a, 24'h380000)) s = S_CLK;
      else if (blk(a, 24'h3A0000)) s = S_SET;
      else if (blk(a, 24'h3C0000)) s = S_VID;
      else if (blk(a, 24'h400000)) s = S_PAL;
      else if (blk(a, 24'h800000)) s = S_CARD;
      else if (blk(a, 24'hD00000)) s = S_SRAM;
      else if (a == 24'h300001 && sz == 2'd0) s = S_KICK;
    end
    b.sel  = (s < 0) ? 16'h0 : (16'h1 << s);
    b.off  = (s < 0) ? 24'h0 : off;
    b.wr   = wr;
    b.sz   = sz;
    b.wd   = wr ? wd : 16'h0;
    b.ob   = (s < 0 && !wr) ? ((sz == 2'd0) ? 16'h00FF : (sz == 2'd2) ? 16'hFF00 : 16'hF0F0) : 16'h0;
    b.last = last;
    return b;
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic issue(input logic [23:0] a, input logic [1:0] sz, input logic wr,
                       input logic [31:0] wd, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_size = sz; in_wr = wr; in_wdata = wd;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    if (sz == 2'd2) begin
      expq.push_back(model(a, sz, wr, wd[31:16], 1'b0)); tagq.push_back(tag);
      expq.push_back(model(a + 24'd2, sz, wr, wd[15:0], 1'b1)); tagq.push_back(tag);
    end else begin
      expq.push_back(model(a, sz, wr, wd[15:0], 1'b1)); tagq.push_back(tag);
    end
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic load_bank(input logic [23:0] v);
    do @(negedge clk); while (expq.size() != 0 || out_valid);
    bank_load = 1'b1; bank_value = v;
    @(posedge clk); #1 bank_load = 1'b0;
    mbank = v;
  endtask

  // output side: back-pressure, stall-hold check and comparison against the model
  initial begin : monitor
    beat_t held, got, e;
    string t;
    bit stalled;
    stalled = 0;
    held = '0;
    forever begin
      @(negedge clk);
      out_ready = rand_ready ? ($urandom % 3 != 0) : 1'b1;
      #1;
      if (rst_n) begin
        got = '{out_sel, out_offset, out_wr, out_size, out_wdata, out_obus, out_last};
        if (stalled) begin
          n_cmp++;
          if (!out_valid || got != held) begin
            n_bad++;
            $display("FAIL R11 stalled beat changed: got %h valid %b, expected %h", got, out_valid, held);
          end
        end
        stalled = out_valid && !out_ready;
        held = got;
        if (out_valid && out_ready) begin
          n_cmp++;
          if (expq.size() == 0) begin
            n_bad++;
            $display("FAIL R11 unexpected beat: got %h, expected none", got);
          end else begin
            e = expq.pop_front();
            t = tagq.pop_front();
            if (got != e) begin
              n_bad++;
              $display("FAIL %s: sel %h/%h off %h/%h wr %b/%b sz %0d/%0d wd %h/%h ob %h/%h last %b/%b (actual/expected)",
                       t, got.sel, e.sel, got.off, e.off, got.wr, e.wr, got.sz, e.sz,
                       got.wd, e.wd, got.ob, e.ob, got.last, e.last);
            end
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin : main
    logic [3:0] subs [8];
    subs = '{4'h0, 4'h1, 4'h2, 4'h4, 4'h8, 4'hA, 4'hC, 4'hF};
    mbank = 24'h100000; // R1: ROM_BYTES above 1 MiB
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    n_cmp++;
    if (out_valid !== 1'b0) begin n_bad++; $display("FAIL R1 out_valid after reset: got %b expected 0", out_valid); end
    n_cmp++;
    if (in_ready !== 1'b1) begin n_bad++; $display("FAIL R1 in_ready after reset: got %b expected 1", in_ready); end

    issue(24'h200010, 2'd1, 0, 0, "R1");
    issue(24'h012346, 2'd1, 0, 0, "R2");
    issue(24'h0FFFFF, 2'd0, 0, 0, "R2");
    issue(24'h1F1234, 2'd1, 1, 32'h0000ABCD, "R4");
    issue(24'h13FFFE, 2'd1, 0, 0, "R4");
    issue(24'hC1FFFE, 2'd1, 0, 0, "R5");
    issue(24'hD00010, 2'd1, 1, 32'h00001357, "R5");
    issue(24'h400100, 2'd1, 0, 0, "R5");
    issue(24'h800002, 2'd0, 1, 32'h000000A5, "R5");
    issue(24'h3C0002, 2'd1, 0, 0, "R6");
    issue(24'h300000, 2'd1, 0, 0, "R6");
    issue(24'h340000, 2'd0, 0, 0, "R6");
    issue(24'h380000, 2'd1, 0, 0, "R6");
    issue(24'h320000, 2'd1, 0, 0, "R6");
    issue(24'h3C0004, 2'd1, 1, 32'h00001111, "R7");
    issue(24'h380000, 2'd0, 1, 32'h00000022, "R7");
    issue(24'h320000, 2'd0, 1, 32'h00000033, "R7");
    issue(24'h3A0000, 2'd1, 1, 32'h00004444, "R7");
    issue(24'h2F0000, 2'd1, 1, 32'h00005555, "R7");
    issue(24'h300001, 2'd0, 1, 32'h00000000, "R8");
    issue(24'h300000, 2'd1, 1, 32'h00000001, "R8");
    issue(24'h000100, 2'd1, 1, 32'h00006666, "R8");
    issue(24'hC00000, 2'd0, 1, 32'h00000077, "R8");
    issue(24'h200000, 2'd1, 1, 32'h00008888, "R8");
    issue(24'h3A0000, 2'd1, 0, 0, "R9");
    issue(24'h500000, 2'd0, 0, 0, "R9");
    issue(24'h500002, 2'd1, 0, 0, "R9");
    issue(24'hC20000, 2'd1, 0, 0, "R9");
    issue(24'h600000, 2'd2, 0, 0, "R9");
    issue(24'h0FFFFE, 2'd2, 0, 0, "R10");
    issue(24'h3C0000, 2'd2, 1, 32'h12345678, "R10");
    issue(24'h1FFFFE, 2'd2, 1, 32'hCAFEF00D, "R10");
    load_bank(24'h300000);
    issue(24'h200004, 2'd1, 0, 0, "R3");
    load_bank(24'hFF0000);
    issue(24'h2FFFFE, 2'd1, 0, 0, "R3");

    rand_ready = 1;
    for (int i = 0; i < 400; i++) begin
      logic [23:0] a;
      logic [1:0] sz;
      a = {4'($urandom % 16), subs[$urandom % 8], 16'($urandom)};
      sz = 2'($urandom % 3);
      if (sz != 2'd0) a[0] = 1'b0;
      if ($urandom % 16 == 0) begin a = 24'h300001; sz = 2'd0; end
      issue(a, sz, 1'($urandom % 2), $urandom, "R11");
      if (i % 100 == 99) load_bank(24'($urandom));
    end
    rand_ready = 0;
    repeat (20) @(negedge clk);
    n_cmp++;
    if (expq.size() != 0) begin
      n_bad++;
      $display("FAIL R11 beats missing: got %0d outstanding, expected 0", expq.size());
    end
    done = 1;
    finish_run();
  end
endmodule